// File: doc/BRIEF.md
# ADC Pair Conversion Trigger Controller

This block decides when each analog pin pair of a pair-converting ADC gets converted. Every pair has a 6-bit trigger-source code. The code chooses the shared global software trigger, the pair's own software trigger bit, or nothing at all. Requests from triggered pairs go to one converter, one pair at a time. The converter answers each request with a one-cycle done pulse. The block then marks that pair ready and holds an interrupt line up.

Re-arming follows the ready flags. While a pair's ready flag is set, the global trigger cannot start another conversion on that pair. Clearing ready flags through the bus also drops the global trigger bit, so software has to set it again for the next round. Registers are written through a simple write-strobe bus. Trigger, pending and ready state comes out on status ports.

Top module: `adcpt_ctrl`

## Requirements
- R1: After synchronous reset, `gtrig_o`, `pend_o`, `rdy_o`, `irq_o` and `conv_start_o` are all 0.
- R2: Writing 1 to bit 0 at address 0 sets the global trigger. From the next cycle, the pending bit rises on every pair whose source code is 0x0F and whose ready and pending bits are both clear. No other pair is affected.
- R3: Requests are served one at a time, lowest-numbered pending pair first. `conv_start_o` is a one-cycle pulse, with `conv_pair_o` naming a pending pair. No new pulse is issued until `conv_done_i` has answered the previous one.
- R4: `conv_done_i` arrives while a request is outstanding. On the next cycle, that pair's pending bit is 0 and its ready bit is 1.
- R5: While a pair's ready bit is set, the global trigger does not raise that pair's pending bit. This holds even if the global bit is rewritten.
- R6: A write to address 1 clears each ready bit whose data bit (bit p for pair p) is 1. The same write always clears the global trigger bit.
- R7: A write to address 2+p with source code 0x01 in bits 5:0 and bit 8 set requests that pair alone. Its pending bit rises on the next cycle, whatever its ready bit. The trigger bit clears itself once the request is taken, so the write causes exactly one conversion.
- R8: A software trigger bit written together with a source code other than 0x01 is discarded. Pairs whose source code is neither 0x0F nor 0x01 (for example 0x00 or 0x05) never go pending.
- R9: `irq_o` is 1 exactly while at least one ready bit is set, and it can only rise on a completion.
- R10: A `conv_done_i` pulse with no outstanding request changes no pending or ready bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Write address: 0 control, 1 ready clear, 2+p pair p config |
| wr_data_i | input | DATA_W | Write data |
| conv_done_i | input | 1 | One-cycle completion pulse from the converter |
| conv_start_o | output | 1 | One-cycle conversion request |
| conv_pair_o | output | PAIR_W | Pair index of the request |
| gtrig_o | output | 1 | Global software trigger bit |
| pend_o | output | N_PAIRS | Per-pair pending bits |
| rdy_o | output | N_PAIRS | Per-pair ready bits |
| irq_o | output | 1 | Completion interrupt, level |

## Verification
First, a global trigger is fired with three pairs on the global code and one disabled. The order of the requests must be 0, 1, 3, which shows both source selection and lowest-first service. The global trigger is then re-fired with ready bits still set, and later fired after a partial ready clear. Only the cleared pair may convert, which tells ready-gated re-arming apart from plain edge triggering. Individual triggers are tried once and again over a set ready bit, then with wrong source codes, and finally a stray done pulse is given while idle. Together these separate self-clearing, code decoding and the handshake guard.

// File: rtl/adcpt_pkg.sv
package adcpt_pkg;

    localparam int SRC_W = 6;

    localparam logic [SRC_W-1:0] SRC_OFF    = 6'h00;
    localparam logic [SRC_W-1:0] SRC_INDIV  = 6'h01;
    localparam logic [SRC_W-1:0] SRC_GLOBAL = 6'h0F;

    localparam int ADR_CTRL   = 0;
    localparam int ADR_RDYCLR = 1;
    localparam int ADR_CFG0   = 2;
    localparam int CFG_TRIG_BIT = 8;

    typedef enum logic {SCH_IDLE, SCH_BUSY} sch_state_e;

    // Per-pair decoded write strobes
    typedef struct packed {
        logic cfg_we;
        logic trig_set;
        logic rdy_clr;
    } pair_wr_t;

    function automatic int idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    function automatic logic is_global(input logic [SRC_W-1:0] s);
        return s == SRC_GLOBAL;
    endfunction

    function automatic logic is_indiv(input logic [SRC_W-1:0] s);
        return s == SRC_INDIV;
    endfunction

endpackage

// File: rtl/adcpt_regs.sv
module adcpt_regs
    import adcpt_pkg::*;
#(
    parameter int N_PAIRS = 4,
    parameter int ADDR_W  = 4,
    parameter int DATA_W  = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en_i,
    input  logic [ADDR_W-1:0]   wr_addr_i,
    input  logic [DATA_W-1:0]   wr_data_i,
    output logic                gtrig_o,
    output logic [SRC_W-1:0]    src_data_o,
    output pair_wr_t            pw_o [N_PAIRS]
);
    logic hit_ctrl, hit_clr;

    assign hit_ctrl   = wr_en_i && (wr_addr_i == ADDR_W'(ADR_CTRL));
    assign hit_clr    = wr_en_i && (wr_addr_i == ADDR_W'(ADR_RDYCLR));
    assign src_data_o = wr_data_i[SRC_W-1:0];

    always_ff @(posedge clk) begin
        if (rst)           gtrig_o <= 1'b0;
        else if (hit_ctrl) gtrig_o <= wr_data_i[0];
        else if (hit_clr)  gtrig_o <= 1'b0;
    end

    for (genvar p = 0; p < N_PAIRS; p++) begin : g_dec
        always_comb begin
            pw_o[p].cfg_we   = wr_en_i && (wr_addr_i == ADDR_W'(ADR_CFG0 + p));
            pw_o[p].trig_set = wr_data_i[CFG_TRIG_BIT];
            pw_o[p].rdy_clr  = hit_clr && wr_data_i[p];
        end
    end
endmodule

// File: rtl/adcpt_pair.sv
module adcpt_pair
    import adcpt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  pair_wr_t          pw_i,
    input  logic [SRC_W-1:0]  src_data_i,
    input  logic              gtrig_i,
    input  logic              done_i,
    output logic              pend_o,
    output logic              rdy_o
);
    logic [SRC_W-1:0] src_q;
    logic             swtrg_q;
    logic             go_glb, go_ind;

    assign go_glb = gtrig_i && is_global(src_q) && !rdy_o && !pend_o;
    assign go_ind = swtrg_q && is_indiv(src_q) && !pend_o;

    always_ff @(posedge clk) begin
        if (rst) begin
            src_q   <= SRC_OFF;
            swtrg_q <= 1'b0;
        end else if (pw_i.cfg_we) begin
            src_q   <= src_data_i;
            swtrg_q <= pw_i.trig_set && is_indiv(src_data_i);
        end else if (go_ind) begin
            swtrg_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                     pend_o <= 1'b0;
        else if (done_i)             pend_o <= 1'b0;
        else if (go_glb || go_ind)   pend_o <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)               rdy_o <= 1'b0;
        else if (done_i)       rdy_o <= 1'b1;
        else if (pw_i.rdy_clr) rdy_o <= 1'b0;
    end
endmodule

// File: rtl/adcpt_sched.sv
module adcpt_sched
    import adcpt_pkg::*;
#(
    parameter int N_PAIRS = 4,
    localparam int PAIR_W = idx_w(N_PAIRS)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N_PAIRS-1:0] pend_i,
    input  logic               conv_done_i,
    output logic               conv_start_o,
    output logic [PAIR_W-1:0]  conv_pair_o,
    output logic [N_PAIRS-1:0] done_vec_o
);
    sch_state_e        state_q;
    logic [PAIR_W-1:0] pick;

    always_comb begin
        pick = '0;
        for (int i = N_PAIRS - 1; i >= 0; i--) begin
            if (pend_i[i]) pick = PAIR_W'(i);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= SCH_IDLE;
            conv_start_o <= 1'b0;
            conv_pair_o  <= '0;
        end else begin
            conv_start_o <= 1'b0;
            case (state_q)
                SCH_IDLE: if (|pend_i) begin
                    conv_start_o <= 1'b1;
                    conv_pair_o  <= pick;
                    state_q      <= SCH_BUSY;
                end
                SCH_BUSY: if (conv_done_i) state_q <= SCH_IDLE;
                default:  state_q <= SCH_IDLE;
            endcase
        end
    end

    always_comb begin
        done_vec_o = '0;
        if (state_q == SCH_BUSY && conv_done_i) done_vec_o[conv_pair_o] = 1'b1;
    end
endmodule

// File: rtl/adcpt_ctrl.sv
module adcpt_ctrl
    import adcpt_pkg::*;
#(
    parameter int N_PAIRS = 4,
    parameter int ADDR_W  = 4,
    parameter int DATA_W  = 16,
    localparam int PAIR_W = idx_w(N_PAIRS)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en_i,
    input  logic [ADDR_W-1:0]  wr_addr_i,
    input  logic [DATA_W-1:0]  wr_data_i,
    input  logic               conv_done_i,
    output logic               conv_start_o,
    output logic [PAIR_W-1:0]  conv_pair_o,
    output logic               gtrig_o,
    output logic [N_PAIRS-1:0] pend_o,
    output logic [N_PAIRS-1:0] rdy_o,
    output logic               irq_o
);
    logic [SRC_W-1:0]   src_data;
    pair_wr_t           pw [N_PAIRS];
    logic [N_PAIRS-1:0] done_vec;

    adcpt_regs #(.N_PAIRS(N_PAIRS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst(rst), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
        .wr_data_i(wr_data_i), .gtrig_o(gtrig_o), .src_data_o(src_data), .pw_o(pw)
    );

    for (genvar p = 0; p < N_PAIRS; p++) begin : g_pair
        adcpt_pair u_pair (
            .clk(clk), .rst(rst), .pw_i(pw[p]), .src_data_i(src_data),
            .gtrig_i(gtrig_o), .done_i(done_vec[p]),
            .pend_o(pend_o[p]), .rdy_o(rdy_o[p])
        );
    end

    adcpt_sched #(.N_PAIRS(N_PAIRS)) u_sched (
        .clk(clk), .rst(rst), .pend_i(pend_o), .conv_done_i(conv_done_i),
        .conv_start_o(conv_start_o), .conv_pair_o(conv_pair_o), .done_vec_o(done_vec)
    );

    assign irq_o = |rdy_o;
endmodule

// File: rtl/adcpt_ctrl_chk.sv
module adcpt_ctrl_chk
    import adcpt_pkg::*;
#(
    parameter int N_PAIRS = 4,
    parameter int ADDR_W  = 4,
    localparam int PAIR_W = idx_w(N_PAIRS)
) (
    input logic               clk,
    input logic               rst,
    input logic               wr_en_i,
    input logic [ADDR_W-1:0]  wr_addr_i,
    input logic               conv_done_i,
    input logic               conv_start_o,
    input logic [PAIR_W-1:0]  conv_pair_o,
    input logic               gtrig_o,
    input logic [N_PAIRS-1:0] pend_o,
    input logic [N_PAIRS-1:0] rdy_o,
    input logic               irq_o
);
    logic              chk_busy;
    logic [PAIR_W-1:0] chk_pair;

    always_ff @(posedge clk) begin
        if (rst) begin
            chk_busy <= 1'b0;
            chk_pair <= '0;
        end else if (conv_start_o) begin
            chk_busy <= 1'b1;
            chk_pair <= conv_pair_o;
        end else if (conv_done_i) begin
            chk_busy <= 1'b0;
        end
    end

    AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        conv_start_o |=> !conv_start_o); // R3
    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst)
        chk_busy |-> !conv_start_o); // R3
    AST_START_HAS_PEND: assert property (@(posedge clk) disable iff (rst)
        conv_start_o |-> pend_o[conv_pair_o]); // R3
    AST_DONE_FLAGS: assert property (@(posedge clk) disable iff (rst)
        (chk_busy && conv_done_i) |=> (rdy_o[chk_pair] && !pend_o[chk_pair])); // R4
    AST_RDYCLR_GTRIG: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && wr_addr_i == ADDR_W'(ADR_RDYCLR)) |=> !gtrig_o); // R6
    AST_IRQ_RISE: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_o) |-> $past(chk_busy && conv_done_i)); // R9
    AST_IDLE_DONE: assert property (@(posedge clk) disable iff (rst)
        (!chk_busy && conv_done_i && !wr_en_i) |=> ($stable(rdy_o) && !$rose(irq_o))); // R10
endmodule

bind adcpt_ctrl adcpt_ctrl_chk #(.N_PAIRS(N_PAIRS), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst(rst), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .conv_done_i(conv_done_i), .conv_start_o(conv_start_o), .conv_pair_o(conv_pair_o),
    .gtrig_o(gtrig_o), .pend_o(pend_o), .rdy_o(rdy_o), .irq_o(irq_o)
);

// File: tb/sim_adcpt_ctrl.sv
`timescale 1ns/1ps
module sim_adcpt_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        conv_done = 1'b0;
    logic        conv_start;
    logic [1:0]  conv_pair;
    logic        gtrig, irq;
    logic [3:0]  pend, rdy;

    int n_chk = 0, n_bad = 0;
    int n_starts = 0;
    int log_pair [16];
    bit cvt_on = 1'b1;

    always #10 clk = ~clk;

    adcpt_ctrl u0 (
        .clk(clk), .rst(rst), .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .conv_done_i(conv_done), .conv_start_o(conv_start), .conv_pair_o(conv_pair),
        .gtrig_o(gtrig), .pend_o(pend), .rdy_o(rdy), .irq_o(irq)
    );

    // Converter model: answers each request with a done pulse after three cycles
    initial forever begin
        @(negedge clk);
        if (cvt_on && conv_start) begin
            if (n_starts < 16) log_pair[n_starts] = int'(conv_pair);
            n_starts++;
            repeat (3) @(negedge clk);
            conv_done = 1'b1;
            @(negedge clk);
            conv_done = 1'b0;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 4'(a); wr_data = 16'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_quiet();
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (pend == 4'b0 && !conv_done) break;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset();
        check("R1 gtrig", int'(gtrig), 0);
        check("R1 pend", int'(pend), 0);
        check("R1 rdy", int'(rdy), 0);
        check("R1 irq", int'(irq), 0);
        check("R1 start", int'(conv_start), 0);
    endtask

    task automatic t_global();
        wr(2, 'h0F); wr(3, 'h0F); wr(4, 'h00); wr(5, 'h0F);
        wr(0, 1);
        @(negedge clk);
        check("R2 pend after global", int'(pend), 'b1011);
        wait_quiet();
        check("R3 start count", n_starts, 3);
        check("R3 order first", log_pair[0], 0);
        check("R3 order second", log_pair[1], 1);
        check("R3 order third", log_pair[2], 3);
        check("R4 rdy", int'(rdy), 'b1011);
        check("R4 pend cleared", int'(pend), 0);
        check("R9 irq up", int'(irq), 1);
        check("R2 gtrig held", int'(gtrig), 1);
    endtask

    task automatic t_block();
        wr(0, 0); wr(0, 1);
        repeat (10) @(negedge clk);
        check("R5 no pend while ready", int'(pend), 0);
        check("R5 no start while ready", n_starts, 3);
    endtask

    task automatic t_clear();
        wr(1, 'b0001);
        check("R6 partial clear", int'(rdy), 'b1010);
        check("R6 gtrig cleared", int'(gtrig), 0);
        check("R9 irq still up", int'(irq), 1);
        wr(0, 1);
        @(negedge clk);
        check("R5 only cleared pair", int'(pend), 'b0001);
        wait_quiet();
        check("R5 one more start", n_starts, 4);
        check("R4 rdy restored", int'(rdy), 'b1011);
        wr(1, 'hF);
        check("R6 full clear", int'(rdy), 0);
        check("R6 gtrig cleared again", int'(gtrig), 0);
        check("R9 irq down", int'(irq), 0);
    endtask

    task automatic t_indiv();
        wr(4, 'h0101);
        @(negedge clk);
        check("R7 single pair pend", int'(pend), 'b0100);
        wait_quiet();
        check("R7 converted", n_starts, 5);
        check("R7 pair index", log_pair[4], 2);
        check("R7 rdy", int'(rdy), 'b0100);
        repeat (10) @(negedge clk);
        check("R7 self-clear", n_starts, 5);
        wr(4, 'h0101);
        @(negedge clk);
        check("R7 not gated by ready", int'(pend), 'b0100);
        wait_quiet();
        check("R7 second conversion", n_starts, 6);
    endtask

    task automatic t_ignore();
        wr(1, 'hF);
        wr(5, 'h0105); wr(3, 'h010F); wr(2, 'h0100);
        repeat (10) @(negedge clk);
        check("R8 trigger bit discarded", int'(pend), 0);
        check("R8 no start", n_starts, 6);
        wr(0, 1);
        @(negedge clk);
        check("R8 only global code", int'(pend), 'b0010);
        wait_quiet();
        check("R8 one start", n_starts, 7);
        check("R8 rdy", int'(rdy), 'b0010);
    endtask

    task automatic t_spurious();
        cvt_on = 1'b0;
        repeat (3) @(negedge clk);
        conv_done = 1'b1;
        @(negedge clk);
        conv_done = 1'b0;
        @(negedge clk);
        check("R10 rdy unchanged", int'(rdy), 'b0010);
        check("R10 pend unchanged", int'(pend), 0);
        check("R10 irq unchanged", int'(irq), 1);
        cvt_on = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_global();
        t_block();
        t_clear();
        t_indiv();
        t_ignore();
        t_spurious();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule